// File: doc/BRIEF.md
# NAND Host Bus Sequencer

This block is the host-side engine for a small-page NAND device that shares one 8-bit bus between commands, addresses and data. A requester hands over one operation at a time: an operation code, a column, a row, a byte count, and for writes a stream of data bytes. The sequencer then plays out the bus cycles that operation needs. It keeps chip enable low for the whole operation. Each byte it writes is marked as a command or an address with the two latch-enable lines, and it is strobed with a low pulse on write enable. Read bytes are pulled with a low pulse on read enable. Between phases the sequencer waits on the ready/busy line.

Each operation differs in its number and kind of address cycles. A page read chooses one of three read commands from the column. Program and erase are framed by a setup byte and a confirm byte, and both end with a status read whose error bit is returned with the completion pulse. The strobe low and high widths and the settling delay before ready/busy is trusted are parameters counted in clock cycles.

Top module: `nand_bus_seq`

## Requirements
- R1: Every byte written to the device is presented on `io_out` with `io_oe` high and `ce_n` low. It is strobed by a `we_n` low pulse, and `io_out` holds steady while `we_n` is low.
- R2: `cle` is high only during command bytes and `ale` only during address bytes. The two are never high together.
- R3: A page read (op 0) sends one read command and then three address bytes: `col[7:0]`, `row[7:0]`, `row[15:8]`. The command is 00h for columns 0–255, 01h for 256–511 and 50h for 512–527.
- R4: After the read address, the sequencer waits T_WB cycles and then for `rb_n` high. It then issues `len` pulses on `re_n` and returns each byte on `rd_data` with a one-cycle `rd_valid`, in order, with `io_oe` low.
- R5: A program (op 1) sends 80h, the three address bytes of R3, `len` data bytes taken from `wr_data`, and then 10h. `wr_ready` pulses once for each data byte consumed.
- R6: An erase (op 2) sends 60h, `row[7:0]`, `row[15:8]`, then D0h.
- R7: After the 10h or D0h confirm, the sequencer waits for ready, sends 70h and reads one status byte, which is also reported on `rd_data`. `done_err` equals bit 0 of that byte.
- R8: A status request (op 3) sends 70h and reads one byte. It returns the byte on `rd_data` and its bit 0 on `done_err`.
- R9: An identify request (op 4) sends 90h, one address byte 00h, then reads `len` bytes.
- R10: A reset request (op 5) sends FFh and waits for ready before completing.
- R11: Every `we_n` and `re_n` low pulse lasts exactly T_LO cycles. Consecutive write pulses are separated by at least T_HI high cycles, and `we_n` and `re_n` are never low together.
- R12: A request is taken only when the sequencer is idle and the op code is 0–5. A request during an operation, or with code 6 or 7, causes no bus activity and no completion.
- R13: Each accepted operation ends with exactly one one-cycle `done` pulse, with `ce_n` high. `done_err` is 0 for read, identify and reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_op | input | 3 | Operation code 0–5 |
| req_col | input | COL_W | Column within the page (0–527) |
| req_row | input | ROW_W | Page row (block and page) |
| req_len | input | LEN_W | Bytes to write or read |
| wr_data | input | 8 | Program data byte currently offered |
| wr_ready | output | 1 | Current `wr_data` byte consumed |
| rd_data | output | 8 | Byte read from the device |
| rd_valid | output | 1 | `rd_data` valid for one cycle |
| done | output | 1 | Operation complete pulse |
| done_err | output | 1 | Status error bit, valid with `done` |
| ce_n | output | 1 | Chip enable, active low |
| we_n | output | 1 | Write strobe, active low |
| re_n | output | 1 | Read strobe, active low |
| cle | output | 1 | Command latch enable |
| ale | output | 1 | Address latch enable |
| io_out | output | 8 | Bus byte driven to the device |
| io_oe | output | 1 | Bus output enable |
| io_in | input | 8 | Bus byte returned by the device |
| rb_n | input | 1 | Device ready (1) / busy (0) |

## Verification
The hardest states to reach from the ports are the edges of the phase transitions. These are a program with zero data bytes, which goes straight from the last address to the confirm byte, a read of length zero, and a second request that arrives in the middle of an operation. The bench reaches them with a bus-level device model that logs every latched byte, drives busy for a fixed time after each confirm, and answers reads with data derived from the address it latched. It sweeps columns across both half-page boundaries and into the spare area. A second request is injected while a program is still sending its address bytes.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  parameter int COL_W = 10;
  parameter int ROW_W = 16;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_PROG  = 3'd1,
    OP_ERASE = 3'd2,
    OP_STAT  = 3'd3,
    OP_ID    = 3'd4,
    OP_RESET = 3'd5
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_CMD1, S_ADDR, S_WDATA, S_CMD2, S_WAIT,
    S_STCMD, S_STRD, S_RDATA, S_DONE
  } st_e;

  localparam logic [7:0] K_RD_LO  = 8'h00;
  localparam logic [7:0] K_RD_HI  = 8'h01;
  localparam logic [7:0] K_RD_SP  = 8'h50;
  localparam logic [7:0] K_PG_SET = 8'h80;
  localparam logic [7:0] K_PG_GO  = 8'h10;
  localparam logic [7:0] K_ER_SET = 8'h60;
  localparam logic [7:0] K_ER_GO  = 8'hD0;
  localparam logic [7:0] K_STATUS = 8'h70;
  localparam logic [7:0] K_IDENT  = 8'h90;
  localparam logic [7:0] K_RESET  = 8'hFF;

  function automatic logic op_legal(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

  // read command from the column: spare area first, then upper half
  function automatic logic [7:0] read_cmd(input logic [COL_W-1:0] col);
    if (col[COL_W-1])      return K_RD_SP;
    else if (col[COL_W-2]) return K_RD_HI;
    return K_RD_LO;
  endfunction

  function automatic logic [7:0] first_cmd(input op_e op, input logic [COL_W-1:0] col);
    case (op)
      OP_READ:  return read_cmd(col);
      OP_PROG:  return K_PG_SET;
      OP_ERASE: return K_ER_SET;
      OP_ID:    return K_IDENT;
      OP_RESET: return K_RESET;
      default:  return K_STATUS;
    endcase
  endfunction

  function automatic logic [1:0] addr_cycles(input op_e op);
    case (op)
      OP_READ, OP_PROG: return 2'd3;
      OP_ERASE:         return 2'd2;
      OP_ID:            return 2'd1;
      default:          return 2'd0;
    endcase
  endfunction

  function automatic logic [7:0] addr_byte(input op_e op, input logic [1:0] i,
                                           input logic [COL_W-1:0] col,
                                           input logic [ROW_W-1:0] row);
    if (op == OP_ID) return 8'h00;
    if (op == OP_ERASE) return (i == 2'd0) ? row[7:0] : row[8 +: 8];
    case (i)
      2'd0:    return col[7:0];
      2'd1:    return row[7:0];
      default: return row[8 +: 8];
    endcase
  endfunction
endpackage

// File: rtl/nbs_strobe_timer.sv
module nbs_strobe_timer #(
  parameter int T_LO = 1,
  parameter int T_HI = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic strobe,
  output logic samp,
  output logic fin
);
  localparam int TOT = T_LO + T_HI;
  localparam int CW  = $clog2(TOT + 1);

  logic [CW-1:0] cnt;

  assign fin    = run && (cnt == CW'(TOT - 1));
  assign strobe = run && (cnt < CW'(T_LO));
  assign samp   = run && (cnt == CW'(T_LO - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!run || fin) cnt <= '0;
    else                 cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/nbs_rb_wait.sv
module nbs_rb_wait #(
  parameter int T_WB = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic rb_n,
  output logic ready
);
  localparam int W = $clog2(T_WB + 2);

  logic [W-1:0] cnt;

  assign ready = arm && (cnt == W'(T_WB)) && rb_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!arm)             cnt <= '0;
    else if (cnt < W'(T_WB))   cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nbs_pkg::*;
#(
  parameter int T_LO  = 1,
  parameter int T_HI  = 1,
  parameter int T_WB  = 2,
  parameter int LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [COL_W-1:0] req_col,
  input  logic [ROW_W-1:0] req_row,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             done_err,
  output logic             ce_n,
  output logic             we_n,
  output logic             re_n,
  output logic             cle,
  output logic             ale,
  output logic [7:0]       io_out,
  output logic             io_oe,
  input  logic [7:0]       io_in,
  input  logic             rb_n
);
  st_e              state;
  op_e              op_q;
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [LEN_W-1:0] len_q, idx;
  logic             err_q;
  logic [7:0]       rd_data_q;
  logic             rd_valid_q;

  // named internal events
  logic idle_w, accept_w, run_w, strobe_w, samp_w, fin_w, ready_w;
  logic rd_phase_w, last_addr_w, last_data_w;

  assign idle_w      = (state == S_IDLE);
  assign accept_w    = idle_w && req_valid && op_legal(req_op);
  assign rd_phase_w  = (state == S_RDATA) || (state == S_STRD);
  assign io_oe       = (state == S_CMD1) || (state == S_ADDR) || (state == S_WDATA) ||
                       (state == S_CMD2) || (state == S_STCMD);
  assign run_w       = io_oe || rd_phase_w;
  assign last_addr_w = (idx == LEN_W'(addr_cycles(op_q)) - LEN_W'(1));
  assign last_data_w = (idx == len_q - LEN_W'(1));

  nbs_strobe_timer #(.T_LO(T_LO), .T_HI(T_HI)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(run_w),
    .strobe(strobe_w), .samp(samp_w), .fin(fin_w)
  );

  nbs_rb_wait #(.T_WB(T_WB)) u_rbw (
    .clk(clk), .rst_n(rst_n), .arm(state == S_WAIT), .rb_n(rb_n), .ready(ready_w)
  );

  assign ce_n     = idle_w || (state == S_DONE);
  assign we_n     = !(strobe_w && io_oe);
  assign re_n     = !(strobe_w && rd_phase_w);
  assign cle      = (state == S_CMD1) || (state == S_CMD2) || (state == S_STCMD);
  assign ale      = (state == S_ADDR);
  assign wr_ready = (state == S_WDATA) && fin_w;
  assign done     = (state == S_DONE);
  assign done_err = done && err_q;
  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;

  always_comb begin
    case (state)
      S_CMD1:  io_out = first_cmd(op_q, col_q);
      S_ADDR:  io_out = addr_byte(op_q, idx[1:0], col_q, row_q);
      S_WDATA: io_out = wr_data;
      S_CMD2:  io_out = (op_q == OP_PROG) ? K_PG_GO : K_ER_GO;
      S_STCMD: io_out = K_STATUS;
      default: io_out = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      op_q       <= OP_READ;
      col_q      <= '0;
      row_q      <= '0;
      len_q      <= '0;
      idx        <= '0;
      err_q      <= 1'b0;
      rd_data_q  <= 8'h00;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      if (samp_w && rd_phase_w) begin
        rd_data_q  <= io_in;
        rd_valid_q <= 1'b1;
        if (state == S_STRD) err_q <= io_in[0];
      end
      case (state)
        S_IDLE: if (accept_w) begin
          op_q  <= op_e'(req_op);
          col_q <= req_col;
          row_q <= req_row;
          len_q <= req_len;
          idx   <= '0;
          err_q <= 1'b0;
          state <= (op_e'(req_op) == OP_STAT) ? S_STCMD : S_CMD1;
        end
        S_CMD1: if (fin_w) begin
          idx   <= '0;
          state <= (addr_cycles(op_q) == 2'd0) ? S_WAIT : S_ADDR;
        end
        S_ADDR: if (fin_w) begin
          if (last_addr_w) begin
            idx <= '0;
            case (op_q)
              OP_READ:  state <= S_WAIT;
              OP_PROG:  state <= (len_q == '0) ? S_CMD2 : S_WDATA;
              OP_ERASE: state <= S_CMD2;
              default:  state <= (len_q == '0) ? S_DONE : S_RDATA;
            endcase
          end else idx <= idx + LEN_W'(1);
        end
        S_WDATA: if (fin_w) begin
          if (last_data_w) begin
            idx   <= '0;
            state <= S_CMD2;
          end else idx <= idx + LEN_W'(1);
        end
        S_CMD2: if (fin_w) state <= S_WAIT;
        S_WAIT: if (ready_w) begin
          case (op_q)
            OP_READ:  state <= (len_q == '0) ? S_DONE : S_RDATA;
            OP_RESET: state <= S_DONE;
            default:  state <= S_STCMD;
          endcase
        end
        S_STCMD: if (fin_w) state <= S_STRD;
        S_STRD:  if (fin_w) state <= S_DONE;
        S_RDATA: if (fin_w) begin
          if (last_data_w) begin
            idx   <= '0;
            state <= S_DONE;
          end else idx <= idx + LEN_W'(1);
        end
        S_DONE:  state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int T_LO = 1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ce_n,
  input logic       we_n,
  input logic       re_n,
  input logic       cle,
  input logic       ale,
  input logic       io_oe,
  input logic [7:0] io_out,
  input logic       accept,
  input logic       done
);
  logic [15:0] we_lo, re_lo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo <= '0;
      re_lo <= '0;
    end else begin
      we_lo <= we_n ? 16'd0 : ((we_lo == 16'hFFFF) ? we_lo : we_lo + 16'd1);
      re_lo <= re_n ? 16'd0 : ((re_lo == 16'hFFFF) ? re_lo : re_lo + 16'd1);
    end
  end

  assert_strobe_ce_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> !ce_n);
  assert_io_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n && !$past(we_n)) |-> $stable(io_out));
  assert_latch_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !re_n |-> !io_oe);
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  assert_we_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (we_lo == 16'(T_LO)));
  assert_re_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(re_n) |-> (re_lo == 16'(T_LO)));
  assert_accept_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> ce_n);
  assert_accept_starts_R12: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !ce_n);
  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_released_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ce_n);
endmodule

bind nand_bus_seq nbs_checker #(.T_LO(T_LO)) u_nbs_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .re_n(re_n),
  .cle(cle), .ale(ale), .io_oe(io_oe), .io_out(io_out),
  .accept(accept_w), .done(done)
);

// File: tb/tb_nand_bus_seq.sv
module tb_nand_bus_seq;
  import nbs_pkg::*;
  localparam int TLO = 2, THI = 1, TWB = 2, LW = 10, BUSY = 6, LOGN = 1024;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0, req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [COL_W-1:0] req_col = '0;
  logic [ROW_W-1:0] req_row = '0;
  logic [LW-1:0] req_len = '0;
  logic [7:0] wr_data, rd_data, io_out, io_in;
  logic wr_ready, rd_valid, done, done_err, ce_n, we_n, re_n, cle, ale, io_oe, rb_n;

  nand_bus_seq #(.T_LO(TLO), .T_HI(THI), .T_WB(TWB), .LEN_W(LW)) dut (.*);

  int nchk = 0, nfail = 0;

  function automatic logic [7:0] pagebyte(input int c, input logic [15:0] r);
    logic [9:0] cc;
    cc = 10'(c);
    return cc[7:0] ^ {cc[9:8], 6'b0} ^ r[7:0] ^ r[15:8];
  endfunction
  function automatic logic [7:0] wpat(input int k);  return 8'(k * 37 + 11); endfunction
  function automatic logic [7:0] idpat(input int k); return 8'(8'hC3 + k * 5); endfunction

  // bus-level device model, all updates on the falling clock edge
  logic [1:0] lk [LOGN];
  logic [7:0] lv [LOGN];
  logic [7:0] rdl [LOGN];
  int n_log = 0, n_rd = 0, n_done = 0, n_wrr = 0, wr_idx = 0;
  logic last_err = 1'b0;
  logic [7:0] last_cmd = 8'h00, a_col = 0, a_rlo = 0, a_rhi = 0;
  logic [7:0] status_val = 8'h40;
  int acnt = 0, rcnt = 0, busy_cnt = 0, rd_base = 0;
  logic stat_mode = 1'b0, id_mode = 1'b0;
  int we_lo_cnt = 0, we_hi_cnt = 0, lo_bad = 0, hi_bad = 0, ce_bad = 0;
  logic have_prev = 1'b0, we_p = 1'b1, re_p = 1'b1;

  assign rb_n    = (busy_cnt == 0);
  assign wr_data = wpat(wr_idx);
  assign io_in   = re_n ? 8'h00 : stat_mode ? status_val : id_mode ? idpat(rcnt) :
                   pagebyte(rd_base + int'(a_col) + rcnt, {a_rhi, a_rlo});

  always @(negedge clk) begin
    if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
    if (ce_n) have_prev = 1'b0;
    if (!we_n) we_lo_cnt++;
    if (we_p && !we_n && have_prev && we_hi_cnt < THI) hi_bad++;
    if (!we_p && we_n) begin
      if (we_lo_cnt != TLO) lo_bad++;
      if (ce_n) ce_bad++;
      we_lo_cnt = 0; we_hi_cnt = 1; have_prev = 1'b1;
      if (n_log < LOGN) begin
        lk[n_log] = (cle && ale) ? 2'd3 : cle ? 2'd0 : ale ? 2'd1 : 2'd2;
        lv[n_log] = io_out;
      end
      n_log++;
      if (cle) begin
        last_cmd = io_out; rcnt = 0; acnt = 0;
        stat_mode = (io_out == 8'h70);
        id_mode   = (io_out == 8'h90);
        if (io_out == 8'h00) rd_base = 0;
        if (io_out == 8'h01) rd_base = 256;
        if (io_out == 8'h50) rd_base = 512;
        if (io_out == 8'h10 || io_out == 8'hD0 || io_out == 8'hFF) busy_cnt = BUSY;
      end else if (ale) begin
        if (acnt == 0) a_col = io_out;
        if (acnt == 1) a_rlo = io_out;
        if (acnt == 2) a_rhi = io_out;
        acnt++;
        if (acnt == 3 && (last_cmd == 8'h00 || last_cmd == 8'h01 || last_cmd == 8'h50))
          busy_cnt = BUSY;
      end
    end else if (we_n && !ce_n) we_hi_cnt++;
    if (!re_p && re_n) begin
      rcnt++;
      if (ce_n) ce_bad++;
    end
    if (rd_valid) begin
      if (n_rd < LOGN) rdl[n_rd] = rd_data;
      n_rd++;
    end
    if (done) begin n_done++; last_err = done_err; end
    if (wr_ready) begin wr_idx++; n_wrr++; end
    we_p = we_n; re_p = re_n;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // issue one request, wait for completion, compare the logged bus traffic
  task automatic run_op(input int op, input int col, input int row, input int len,
                        input logic [7:0] st, input bit poke);
    int ek[32]; int ev[32]; int er[32];
    int ne = 0, nr = 0, n0, r0, d0, w0, w_at, t = 0;
    string tg;
    logic exp_err = 1'b0;
    tg = (op == 0) ? "R3" : (op == 1) ? "R5" : (op == 2) ? "R6" :
         (op == 3) ? "R8" : (op == 4) ? "R9" : "R10";
    status_val = st;
    n0 = n_log; r0 = n_rd; d0 = n_done; w0 = n_wrr; w_at = wr_idx;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_col = COL_W'(col);
    req_row = ROW_W'(row); req_len = LW'(len);
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      req_valid = 1'b1; req_op = 3'd2; req_row = 16'hBEEF;
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (n_done == d0 && t < 4000) begin @(negedge clk); t++; end
    repeat (BUSY + 20) @(negedge clk);
    case (op)
      0: begin
        ek[0] = 0; ev[0] = (col / 256 == 0) ? 8'h00 : (col / 256 == 1) ? 8'h01 : 8'h50;
        ek[1] = 1; ev[1] = col % 256; ek[2] = 1; ev[2] = row % 256; ek[3] = 1; ev[3] = row / 256;
        ne = 4; nr = len;
        for (int k = 0; k < len; k++) er[k] = int'(pagebyte(col + k, 16'(row)));
      end
      1: begin
        ek[0] = 0; ev[0] = 8'h80;
        ek[1] = 1; ev[1] = col % 256; ek[2] = 1; ev[2] = row % 256; ek[3] = 1; ev[3] = row / 256;
        for (int k = 0; k < len; k++) begin ek[4+k] = 2; ev[4+k] = int'(wpat(w_at + k)); end
        ek[4+len] = 0; ev[4+len] = 8'h10; ek[5+len] = 0; ev[5+len] = 8'h70;
        ne = 6 + len; nr = 1; er[0] = int'(st); exp_err = st[0];
      end
      2: begin
        ek[0] = 0; ev[0] = 8'h60; ek[1] = 1; ev[1] = row % 256; ek[2] = 1; ev[2] = row / 256;
        ek[3] = 0; ev[3] = 8'hD0; ek[4] = 0; ev[4] = 8'h70;
        ne = 5; nr = 1; er[0] = int'(st); exp_err = st[0];
      end
      3: begin
        ek[0] = 0; ev[0] = 8'h70; ne = 1; nr = 1; er[0] = int'(st); exp_err = st[0];
      end
      4: begin
        ek[0] = 0; ev[0] = 8'h90; ek[1] = 1; ev[1] = 0; ne = 2; nr = len;
        for (int k = 0; k < len; k++) er[k] = int'(idpat(k));
      end
      default: begin ek[0] = 0; ev[0] = 8'hFF; ne = 1; nr = 0; end
    endcase
    chk(n_done - d0 == 1, "R13 done count", n_done - d0, 1);
    chk(last_err == exp_err, (op == 1 || op == 2) ? "R7 status error" : "R13 done_err",
        int'(last_err), int'(exp_err));
    chk(n_log - n0 == ne, {tg, " byte count"}, n_log - n0, ne);
    for (int k = 0; k < ne && k < n_log - n0; k++) begin
      chk(int'(lk[n0+k]) == ek[k], "R2 cycle kind", int'(lk[n0+k]), ek[k]);
      chk(int'(lv[n0+k]) == ev[k], {tg, " bus byte"}, int'(lv[n0+k]), ev[k]);
    end
    chk(n_rd - r0 == nr, "R4 read count", n_rd - r0, nr);
    for (int k = 0; k < nr && k < n_rd - r0; k++)
      chk(int'(rdl[r0+k]) == er[k], (op == 0) ? "R4 read data" : {tg, " read data"},
          int'(rdl[r0+k]), er[k]);
    if (op == 1) chk(n_wrr - w0 == len, "R5 wr_ready count", n_wrr - w0, len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R13 actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int cols[10] = '{0, 1, 127, 255, 256, 300, 511, 512, 520, 527};
    int pcols[3] = '{0, 300, 515};
    int erows[3] = '{0, 16'h1234, 16'hFFFF};
    int n0, d0;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && re_n && !cle && !ale && !done && !rd_valid, "R1 reset idle",
        {ce_n, we_n, re_n, cle, ale, done}, 6'b111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 10; i++)
      run_op(0, cols[i], (16'h1357 + i * 4099) % 65536, (i == 9) ? 1 : 3, 8'h40, 1'b0);
    run_op(0, 100, 16'h0042, 0, 8'h40, 1'b0);
    for (int i = 0; i < 3; i++)
      run_op(1, pcols[i], 16'h2000 + i * 33, i * 2 + (i == 2 ? 1 : 0), (i % 2) ? 8'h41 : 8'h40, 1'b0);
    run_op(1, 64, 16'h0A0B, 4, 8'h41, 1'b1);   // R12 mid-operation request
    for (int i = 0; i < 3; i++)
      run_op(2, 0, erows[i], 0, (i % 2) ? 8'h40 : 8'h41, 1'b0);
    run_op(3, 0, 0, 0, 8'hC0, 1'b0);
    run_op(3, 0, 0, 0, 8'hC1, 1'b0);
    run_op(4, 0, 0, 2, 8'h40, 1'b0);
    run_op(4, 0, 0, 4, 8'h40, 1'b0);
    run_op(5, 0, 0, 0, 8'h40, 1'b0);
    for (int c = 6; c < 8; c++) begin   // R12 illegal codes
      n0 = n_log; d0 = n_done;
      @(negedge clk); req_valid = 1'b1; req_op = 3'(c);
      @(negedge clk); req_valid = 1'b0;
      repeat (30) @(negedge clk);
      chk(n_log == n0 && ce_n, "R12 illegal op bus", n_log - n0, 0);
      chk(n_done == d0, "R12 illegal op done", n_done - d0, 0);
    end
    run_op(0, 260, 16'h7777, 2, 8'h40, 1'b0);
    chk(lo_bad == 0, "R11 low width", lo_bad, 0);
    chk(hi_bad == 0, "R11 high width", hi_bad, 0);
    chk(ce_bad == 0, "R1 strobe without ce", ce_bad, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule